// File: doc/BRIEF.md
# Symmetric Row-Scan Token Sequencer

This block selects one row of an electroluminescent panel at a time. A single active token moves one row position on every rising clock edge. The token enters through a reset/token pin. When that pin is sampled high, all shift stages are cleared and the token is placed in the first position of the scan order. Two static inputs choose one of four scan orders: full ascending, full descending, and two split symmetric orders that start at the centre of the array and wrap to the far half.

There are two token pins, A and B. The scan direction input decides which one acts as the token input and which one drives the cascade output. This lets several blocks be chained in either direction. Each row has a drive-enable bit and a drive-value bit that together stand in for a push-pull or high-impedance pad. Only the row holding the token is driven, at the level chosen by the polarity input. A global float input releases every row without disturbing the scan.

Top module: `row_token_sequencer`

## Requirements
- R1: While `rst_n` is low, asynchronously, every bit of `row_drv_en` and `row_drv_val` is 0, and `tok_a_out` and `tok_b_out` are 0.
- R2: When the active token input is high at a rising edge, all stages clear and the token sits in the first position of the current order after that edge. While the input stays high, the token stays at that first position.
- R3: With the token input low, the token moves one position per rising edge. After the edge that follows the last position, no row is enabled.
- R4: With `scan_dir`=0 and `split_mode`=0, the order is row N down to row 1. Rows are numbered 1..N, and row k is bit k-1 of the row buses.
- R5: With `scan_dir`=1 and `split_mode`=0, the order is row 1 up to row N.
- R6: With `scan_dir`=0 and `split_mode`=1, the order is row N/2 down to row 1, then row N down to row N/2+1.
- R7: With `scan_dir`=1 and `split_mode`=1, the order is row N/2+1 up to row N, then row 1 up to row N/2.
- R8: The pin roles follow `scan_dir`:
  - With `scan_dir`=1, A is the token input (`tok_a_oe`=0, `tok_a_out`=0) and B is the cascade output (`tok_b_oe`=1).
  - With `scan_dir`=0, the roles swap.
  - A high level on the pin in the output role launches no token.
- R9: The cascade output on the driving pin is the token input delayed by N clock edges. It is high in the same cycle that the last position of the order is selected, so a downstream block samples it on the next edge.
- R10: The enabled row has `row_drv_val` equal to `drive_pol`. Every row that is not enabled has `row_drv_val`=0.
- R11: While `hiz_all` is high, every `row_drv_en` bit is 0. The token keeps moving, and rows are driven again from its current position once `hiz_all` falls.
- R12: At most one `row_drv_en` bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the token moves on rising edges |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| scan_dir | input | 1 | Direction select; static outside reset |
| split_mode | input | 1 | Selects the split symmetric orders; static outside reset |
| drive_pol | input | 1 | Level driven onto the selected row |
| hiz_all | input | 1 | Releases every row when high |
| tok_a_in | input | 1 | Pin A receive side |
| tok_a_out | output | 1 | Pin A drive side (cascade) |
| tok_a_oe | output | 1 | Pin A drives when 1 |
| tok_b_in | input | 1 | Pin B receive side |
| tok_b_out | output | 1 | Pin B drive side (cascade) |
| tok_b_oe | output | 1 | Pin B drives when 1 |
| row_drv_en | output | N_ROWS | Per-row drive enable (0 = floating) |
| row_drv_val | output | N_ROWS | Per-row driven level |

## Verification
The bench builds the block with its default of 40 rows, the full panel width. At that size a complete 40-position walk in each of the four orders is checked against an independently tabulated order. The walk covers the seam between the two halves at rows 20 and 21 and the full 40-edge cascade delay. Directed cases cover a restart in the middle of a scan, a held token input, a float window in the middle of a scan, both polarities, a token on the pin in the output role, and an asynchronous clear in the middle of a cycle.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;

   // Encoding is {scan_dir, split_mode}
   typedef enum logic [1:0] {
      ORD_DESC       = 2'b00,
      ORD_SPLIT_DESC = 2'b01,
      ORD_ASC        = 2'b10,
      ORD_SPLIT_ASC  = 2'b11
   } scan_order_e;

   // Chain position (0 = first selected) that feeds a given 0-based row
   function automatic int chain_pos(int row, int n, scan_order_e ord);
      int h;
      h = n / 2;
      case (ord)
         ORD_DESC:       return n - 1 - row;
         ORD_ASC:        return row;
         ORD_SPLIT_DESC: return (row < h) ? (h - 1 - row) : (n + h - 1 - row);
         default:        return (row >= h) ? (row - h) : (row + h);
      endcase
   endfunction

endpackage

// File: rtl/token_chain.sv
module token_chain #(
   parameter int N_STAGES = 40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch,
   output logic [N_STAGES-1:0] stage
);
   localparam logic [N_STAGES-1:0] SEED = {{(N_STAGES-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage <= '0;
      else if (launch)
         stage <= SEED;
      else
         stage <= {stage[N_STAGES-2:0], 1'b0};
   end
endmodule

// File: rtl/cascade_delay.sv
module cascade_delay #(
   parameter int DEPTH = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [DEPTH-1:0] line_q;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= '0;
            else        line_q <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= '0;
            else        line_q <= {line_q[DEPTH-2:0], din};
         end
      end
   endgenerate

   assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/row_router.sv
module row_router
   import row_seq_pkg::*;
#(
   parameter int N_ROWS = 40
) (
   input  logic [N_ROWS-1:0] stage,
   input  scan_order_e       order,
   output logic [N_ROWS-1:0] row_hot
);
   generate
      for (genvar r = 0; r < N_ROWS; r++) begin : g_row
         localparam int P_DESC  = chain_pos(r, N_ROWS, ORD_DESC);
         localparam int P_ASC   = chain_pos(r, N_ROWS, ORD_ASC);
         localparam int P_SDESC = chain_pos(r, N_ROWS, ORD_SPLIT_DESC);
         localparam int P_SASC  = chain_pos(r, N_ROWS, ORD_SPLIT_ASC);
         always_comb begin
            case (order)
               ORD_DESC:       row_hot[r] = stage[P_DESC];
               ORD_ASC:        row_hot[r] = stage[P_ASC];
               ORD_SPLIT_DESC: row_hot[r] = stage[P_SDESC];
               default:        row_hot[r] = stage[P_SASC];
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/row_driver.sv
module row_driver #(
   parameter int N_ROWS = 40
) (
   input  logic [N_ROWS-1:0] row_hot,
   input  logic              pol,
   input  logic              hiz_all,
   output logic [N_ROWS-1:0] drv_en,
   output logic [N_ROWS-1:0] drv_val
);
   assign drv_en  = hiz_all ? '0 : row_hot;
   assign drv_val = drv_en & {N_ROWS{pol}};
endmodule

// File: rtl/row_token_sequencer.sv
module row_token_sequencer
   import row_seq_pkg::*;
#(
   parameter int N_ROWS = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_dir,
   input  logic              split_mode,
   input  logic              drive_pol,
   input  logic              hiz_all,
   input  logic              tok_a_in,
   output logic              tok_a_out,
   output logic              tok_a_oe,
   input  logic              tok_b_in,
   output logic              tok_b_out,
   output logic              tok_b_oe,
   output logic [N_ROWS-1:0] row_drv_en,
   output logic [N_ROWS-1:0] row_drv_val
);
   generate
      if (N_ROWS < 2 || (N_ROWS % 2) != 0) begin : g_bad_rows
         $error("row_token_sequencer: N_ROWS must be even and at least 2");
      end
   endgenerate

   scan_order_e       order;
   logic              tok_in;
   logic              casc;
   logic [N_ROWS-1:0] stage;
   logic [N_ROWS-1:0] row_hot;

   assign order  = scan_order_e'({scan_dir, split_mode});
   assign tok_in = scan_dir ? tok_a_in : tok_b_in;

   token_chain #(.N_STAGES(N_ROWS)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (tok_in),
      .stage  (stage)
   );

   cascade_delay #(.DEPTH(N_ROWS)) u_casc (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (tok_in),
      .dout  (casc)
   );

   row_router #(.N_ROWS(N_ROWS)) u_router (
      .stage   (stage),
      .order   (order),
      .row_hot (row_hot)
   );

   row_driver #(.N_ROWS(N_ROWS)) u_drv (
      .row_hot (row_hot),
      .pol     (drive_pol),
      .hiz_all (hiz_all),
      .drv_en  (row_drv_en),
      .drv_val (row_drv_val)
   );

   assign tok_a_oe  = ~scan_dir;
   assign tok_b_oe  = scan_dir;
   assign tok_a_out = ~scan_dir & casc;
   assign tok_b_out = scan_dir & casc;
endmodule

// File: rtl/row_token_sequencer_chk.sv
module row_token_sequencer_chk #(
   parameter int N_ROWS = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scan_dir,
   input logic              drive_pol,
   input logic              hiz_all,
   input logic              tok_a_in,
   input logic              tok_a_out,
   input logic              tok_a_oe,
   input logic              tok_b_in,
   input logic              tok_b_out,
   input logic              tok_b_oe,
   input logic [N_ROWS-1:0] row_drv_en,
   input logic [N_ROWS-1:0] row_drv_val
);
   logic seen_edge;
   logic tin;

   assign tin = scan_dir ? tok_a_in : tok_b_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_edge <= 1'b0;
      else        seen_edge <= 1'b1;
   end

   // R12
   one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_drv_en));

   // R11
   hiz_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_all |-> (row_drv_en == '0));

   // R8
   pin_role_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_dir |-> (tok_b_oe && !tok_a_oe && !tok_a_out));

   // R8
   pin_role_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_dir |-> (tok_a_oe && !tok_b_oe && !tok_b_out));

   // R10
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_drv_val & ~row_drv_en) == '0);

   // R10
   pol_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_pol |-> (row_drv_val == row_drv_en));

   // R2
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && $past(tin) && !hiz_all) |-> ($countones(row_drv_en) == 1));

   // R3
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && !$past(tin) && !$past(hiz_all) && !hiz_all &&
       ($past(row_drv_en) != '0)) |-> (row_drv_en != $past(row_drv_en)));
endmodule

bind row_token_sequencer row_token_sequencer_chk #(.N_ROWS(N_ROWS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scan_dir    (scan_dir),
   .drive_pol   (drive_pol),
   .hiz_all     (hiz_all),
   .tok_a_in    (tok_a_in),
   .tok_a_out   (tok_a_out),
   .tok_a_oe    (tok_a_oe),
   .tok_b_in    (tok_b_in),
   .tok_b_out   (tok_b_out),
   .tok_b_oe    (tok_b_oe),
   .row_drv_en  (row_drv_en),
   .row_drv_val (row_drv_val)
);

// File: tb/row_token_sequencer_bench.sv
`timescale 1ns/1ps
module row_token_sequencer_bench;
   localparam int N = 40;
   localparam int H = N / 2;
   // dir, split, first row of segment 1, first row of segment 2, step
   localparam int VEC [4][5] = '{
      '{0, 0, N,     0, -1},
      '{1, 0, 1,     0,  1},
      '{0, 1, H,     N, -1},
      '{1, 1, H + 1, 1,  1}
   };

   logic clk = 0, rst_n = 0, scan_dir = 0, split_mode = 0;
   logic drive_pol = 1, hiz_all = 0, tok_a_in = 0, tok_b_in = 0;
   logic tok_a_out, tok_a_oe, tok_b_out, tok_b_oe;
   logic [N-1:0] row_drv_en, row_drv_val;

   int checks = 0, errors = 0, cycles = 0;

   always #4 clk = ~clk;

   row_token_sequencer #(.N_ROWS(N)) u_row_token_sequencer (
      .clk(clk), .rst_n(rst_n), .scan_dir(scan_dir), .split_mode(split_mode),
      .drive_pol(drive_pol), .hiz_all(hiz_all),
      .tok_a_in(tok_a_in), .tok_a_out(tok_a_out), .tok_a_oe(tok_a_oe),
      .tok_b_in(tok_b_in), .tok_b_out(tok_b_out), .tok_b_oe(tok_b_oe),
      .row_drv_en(row_drv_en), .row_drv_val(row_drv_val)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   // 1-based index of the single enabled row, 0 if none, -1 if several
   function automatic int hot_row();
      int idx = 0, cnt = 0;
      for (int i = 0; i < N; i++) if (row_drv_en[i]) begin idx = i + 1; cnt++; end
      return (cnt > 1) ? -1 : idx;
   endfunction

   task automatic check(int act, int exp, string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic d, logic s);
      @(negedge clk);
      rst_n = 0; scan_dir = d; split_mode = s;
      tok_a_in = 0; tok_b_in = 0; hiz_all = 0; drive_pol = 1;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic set_tok(logic v);
      if (scan_dir) tok_a_in = v; else tok_b_in = v;
   endtask

   function automatic int casc_out();
      return scan_dir ? int'(tok_b_out) : int'(tok_a_out);
   endfunction

   initial begin
      // Vector walk: every order over all positions
      for (int v = 0; v < 4; v++) begin
         int len;
         do_reset(VEC[v][0][0], VEC[v][1][0]);
         check(hot_row(), 0, "R1 no row after reset");
         check(int'(tok_a_out | tok_b_out), 0, "R1 cascade low after reset");
         check(int'(tok_a_oe), 1 - VEC[v][0], "R8 pin A role");
         check(int'(tok_b_oe), VEC[v][0], "R8 pin B role");
         len = VEC[v][1] ? H : N;
         set_tok(1);
         @(negedge clk);
         set_tok(0);
         for (int p = 0; p < N; p++) begin
            int exp_row;
            exp_row = (p < len) ? VEC[v][2] + VEC[v][4] * p
                                : VEC[v][3] + VEC[v][4] * (p - len);
            case (v)
               0: check(hot_row(), exp_row, "R4 descending order");
               1: check(hot_row(), exp_row, "R5 ascending order");
               2: check(hot_row(), exp_row, "R6 split descending order");
               default: check(hot_row(), exp_row, "R7 split ascending order");
            endcase
            if (p == 0) check(hot_row(), VEC[v][2], "R2 first position");
            if (p == 5) check(int'(row_drv_val), int'(row_drv_en), "R10 high polarity");
            if (p >= N - 2) check(casc_out(), (p == N - 1) ? 1 : 0, "R9 cascade timing");
            @(negedge clk);
         end
         check(hot_row(), 0, "R3 token leaves after last position");
         check(casc_out(), 0, "R9 cascade single pulse");
      end

      // Float window mid-scan, ascending order
      do_reset(1, 0);
      set_tok(1); @(negedge clk); set_tok(0);   // row 1
      repeat (3) @(negedge clk);                 // row 4
      check(hot_row(), 4, "R3 one step per edge");
      hiz_all = 1; #1;
      check(hot_row(), 0, "R11 float releases all rows");
      repeat (2) @(negedge clk);                 // token at row 6
      check(hot_row(), 0, "R11 still floating");
      hiz_all = 0; #1;
      check(hot_row(), 6, "R11 scan continued while floating");

      // Low polarity
      drive_pol = 0; #1;
      check(int'(row_drv_val != '0), 0, "R10 low polarity drives 0");
      check(hot_row(), 6, "R10 row still enabled at low polarity");
      drive_pol = 1;

      // Restart mid-scan
      repeat (4) @(negedge clk);                 // row 10
      set_tok(1); @(negedge clk);
      check(hot_row(), 1, "R2 restart clears and relaunches");
      @(negedge clk);
      check(hot_row(), 1, "R2 held input keeps first position");
      set_tok(0); @(negedge clk);
      check(hot_row(), 2, "R3 advance after release");

      // Token on the output-role pin is ignored (dir=1: B is output)
      do_reset(1, 1);
      tok_b_in = 1; @(negedge clk); tok_b_in = 0;
      check(hot_row(), 0, "R8 output-role pin ignored");
      check(int'(tok_a_out), 0, "R8 input-role pin not driven");

      // Asynchronous clear mid-cycle
      tok_a_in = 1; @(negedge clk); tok_a_in = 0;
      check(hot_row(), H + 1, "R7 split ascending start");
      #2 rst_n = 0; #1;
      check(hot_row(), 0, "R1 async clear of rows");
      check(int'(row_drv_val), 0, "R1 async clear of values");
      @(negedge clk); rst_n = 1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule